// File: doc/BRIEF.md
# Segmented Address Generator

This block turns an operand description into a 20-bit physical address for a 16-bit segmented machine. For a memory operand it reads the two-bit mode field and the three-bit register/memory field of the operand-descriptor byte, adds the chosen base and index registers and an optional 8-bit or 16-bit displacement, and wraps the sum at 16 bits. It then picks a segment register, either from an explicit override prefix or by default, and forms the physical address as the segment value moved up four bit places plus the offset.

A second path serves instruction fetch. It pairs the code segment with the instruction pointer and bypasses the operand decode. The result, the offset used and the segment code are captured in an output register when a request is presented. The register produces a one-cycle valid pulse and holds its data between requests.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_addr`, `out_offset` and `out_seg` are 0 until the first accepted request.
- R2: A request is accepted when `req_valid` is 1 and it is either a fetch or has `ea_mod` other than 3. `out_valid` is 1 in exactly the cycle after an accepted request. With no accepted request, `out_addr`, `out_offset` and `out_seg` keep their previous values.
- R3: A fetch request (`req_fetch`=1) gives offset = `reg_ip` and segment code 1 (code segment), whatever the mode, register/memory and override inputs are.
- R4: With `ea_mod`=0, `ea_rm` values 0, 1, 2 and 3 give BX+SI, BX+DI, BP+SI and BP+DI respectively, summed modulo 2^16.
- R5: With `ea_mod`=0, `ea_rm` 4 gives SI, 5 gives DI and 7 gives BX.
- R6: With `ea_mod`=0 and `ea_rm`=6, the offset is `ea_disp` alone, with no register added.
- R7: With `ea_mod`=1, only `ea_disp[7:0]` is used. It is sign-extended to 16 bits and added to the base, and `ea_disp[15:8]` has no effect.
- R8: With `ea_mod`=2, the full 16-bit `ea_disp` is added to the base. For `ea_rm`=6 in modes 1 and 2 the base is BP. All sums wrap modulo 2^16.
- R9: Without an override, the segment is SS (code 2) when the base is BP (`ea_rm` 2 or 3, or `ea_rm` 6 with `ea_mod` not 0). Otherwise it is DS (code 3). Segment codes are ES=0, CS=1, SS=2, DS=3.
- R10: For a non-fetch request with `ovr_en`=1, the segment code equals `ovr_seg`, overriding R9. For a fetch request, `ovr_en` has no effect.
- R11: `out_addr` = (segment value × 16 + zero-extended offset) modulo 2^20.
- R12: A non-fetch request with `ea_mod`=3 (register operand) is not accepted. `out_valid` stays 0 and the held outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_fetch | input | 1 | 1 = instruction fetch path, 0 = memory operand |
| ea_mod | input | 2 | Operand mode field |
| ea_rm | input | 3 | Register/memory field |
| ea_disp | input | 16 | Displacement (low byte only in mode 1) |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_ip | input | 16 | Instruction pointer |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result valid pulse |
| out_addr | output | 20 | Physical address |
| out_offset | output | 16 | Offset used |
| out_seg | output | 2 | Segment code used |

## Verification
Every piece of internal state reaches the ports within one clock. A wrong base/index choice or a wrong displacement extension shows as a bad `out_offset` in the cycle after the request. A wrong segment choice shows as a bad `out_seg`, and the address is wrong as well. A composition fault that applies the shift after the add, or drops the carry wrap, appears only in `out_addr`. The directed cases put nonzero bits near both wrap points so that such faults are exposed. A faulty accept or hold path shows as a missing or extra `out_valid` pulse, or as held data that drifts while the block is idle.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_code_e;

   localparam logic [1:0] MOD_NODISP = 2'b00;
   localparam logic [1:0] MOD_DISP8  = 2'b01;
   localparam logic [1:0] MOD_DISP16 = 2'b10;
   localparam logic [1:0] MOD_REGDIR = 2'b11;

   localparam logic [2:0] RM_DIRECT  = 3'd6;

endpackage

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
   import sag_pkg::*;
#(
   parameter int OFS_W   = 16,
   parameter int SDISP_W = 8
) (
   input  logic [1:0]       mod_i,
   input  logic [2:0]       rm_i,
   input  logic [OFS_W-1:0] disp_i,
   input  logic [OFS_W-1:0] bx_i,
   input  logic [OFS_W-1:0] bp_i,
   input  logic [OFS_W-1:0] si_i,
   input  logic [OFS_W-1:0] di_i,
   output logic [OFS_W-1:0] offset_o,
   output logic             bp_base_o
);

   localparam int EXT_W = OFS_W - SDISP_W;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("sag_offset_unit: OFS_W must exceed SDISP_W");
      end
   endgenerate

   logic [OFS_W-1:0] base_v;
   logic [OFS_W-1:0] index_v;
   logic [OFS_W-1:0] short_disp;
   logic [OFS_W-1:0] disp_ext;

   assign short_disp = {{EXT_W{disp_i[SDISP_W-1]}}, disp_i[SDISP_W-1:0]};

   always_comb begin
      base_v  = '0;
      index_v = '0;
      case (rm_i)
         3'd0: begin base_v = bx_i; index_v = si_i; end
         3'd1: begin base_v = bx_i; index_v = di_i; end
         3'd2: begin base_v = bp_i; index_v = si_i; end
         3'd3: begin base_v = bp_i; index_v = di_i; end
         3'd4: base_v = si_i;
         3'd5: base_v = di_i;
         3'd6: base_v = (mod_i == MOD_NODISP) ? '0 : bp_i;
         default: base_v = bx_i;
      endcase
   end

   always_comb begin
      case (mod_i)
         MOD_NODISP: disp_ext = (rm_i == RM_DIRECT) ? disp_i : '0;
         MOD_DISP8:  disp_ext = short_disp;
         MOD_DISP16: disp_ext = disp_i;
         default:    disp_ext = '0;
      endcase
   end

   assign offset_o  = base_v + index_v + disp_ext;

   assign bp_base_o = (rm_i == 3'd2) || (rm_i == 3'd3) ||
                      ((rm_i == RM_DIRECT) && (mod_i != MOD_NODISP));

endmodule

// File: rtl/sag_segment_select.sv
module sag_segment_select
   import sag_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic             fetch_i,
   input  logic             ovr_en_i,
   input  logic [1:0]       ovr_seg_i,
   input  logic             bp_base_i,
   input  logic [SEG_W-1:0] es_i,
   input  logic [SEG_W-1:0] cs_i,
   input  logic [SEG_W-1:0] ss_i,
   input  logic [SEG_W-1:0] ds_i,
   output logic [1:0]       code_o,
   output logic [SEG_W-1:0] value_o
);

   seg_code_e pick;

   always_comb begin
      if (fetch_i)
         pick = SEG_CS;
      else if (ovr_en_i)
         pick = seg_code_e'(ovr_seg_i);
      else if (bp_base_i)
         pick = SEG_SS;
      else
         pick = SEG_DS;
   end

   always_comb begin
      case (pick)
         SEG_ES:  value_o = es_i;
         SEG_CS:  value_o = cs_i;
         SEG_SS:  value_o = ss_i;
         default: value_o = ds_i;
      endcase
   end

   assign code_o = pick;

   always_comb begin
      AST_FETCH_NOT_OVERRIDDEN: assert (!fetch_i || pick == SEG_CS); // R3
   end

endmodule

// File: rtl/sag_phys_compose.sv
module sag_phys_compose #(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int SHIFT = 4
) (
   input  logic [SEG_W-1:0]       seg_i,
   input  logic [OFS_W-1:0]       offset_i,
   output logic [SEG_W+SHIFT-1:0] phys_o
);

   localparam int PA_W = SEG_W + SHIFT;

   generate
      if (OFS_W > PA_W) begin : g_bad_ofs
         $error("sag_phys_compose: offset wider than physical address");
      end
      if (SHIFT < 1) begin : g_bad_shift
         $error("sag_phys_compose: SHIFT must be positive");
      end
   endgenerate

   logic [PA_W-1:0] seg_scaled;
   logic [PA_W-1:0] ofs_zext;

   assign seg_scaled = {seg_i, {SHIFT{1'b0}}};
   assign ofs_zext   = PA_W'(offset_i);
   assign phys_o     = seg_scaled + ofs_zext;

   always_comb begin
      AST_LOW_BITS_FROM_OFFSET: assert (phys_o[SHIFT-1:0] == offset_i[SHIFT-1:0]); // R11
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import sag_pkg::*;
#(
   parameter int OFS_W   = 16,
   parameter int SEG_W   = 16,
   parameter int SHIFT   = 4,
   parameter int SDISP_W = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int PA_W   = SEG_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_fetch,
   input  logic [1:0]       ea_mod,
   input  logic [2:0]       ea_rm,
   input  logic [OFS_W-1:0] ea_disp,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [OFS_W-1:0] reg_bx,
   input  logic [OFS_W-1:0] reg_bp,
   input  logic [OFS_W-1:0] reg_si,
   input  logic [OFS_W-1:0] reg_di,
   input  logic [OFS_W-1:0] reg_ip,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   output logic             out_valid,
   output logic [PA_W-1:0]  out_addr,
   output logic [OFS_W-1:0] out_offset,
   output logic [1:0]       out_seg
);

   logic [OFS_W-1:0] ea_offset;
   logic             bp_base;
   logic [OFS_W-1:0] sel_offset;
   logic [1:0]       seg_code;
   logic [SEG_W-1:0] seg_value;
   logic [PA_W-1:0]  phys;
   logic             accept;

   sag_offset_unit #(
      .OFS_W   (OFS_W),
      .SDISP_W (SDISP_W)
   ) u_offset (
      .mod_i     (ea_mod),
      .rm_i      (ea_rm),
      .disp_i    (ea_disp),
      .bx_i      (reg_bx),
      .bp_i      (reg_bp),
      .si_i      (reg_si),
      .di_i      (reg_di),
      .offset_o  (ea_offset),
      .bp_base_o (bp_base)
   );

   sag_segment_select #(
      .SEG_W (SEG_W)
   ) u_segsel (
      .fetch_i   (req_fetch),
      .ovr_en_i  (ovr_en),
      .ovr_seg_i (ovr_seg),
      .bp_base_i (bp_base),
      .es_i      (seg_es),
      .cs_i      (seg_cs),
      .ss_i      (seg_ss),
      .ds_i      (seg_ds),
      .code_o    (seg_code),
      .value_o   (seg_value)
   );

   assign sel_offset = req_fetch ? reg_ip : ea_offset;

   sag_phys_compose #(
      .SEG_W (SEG_W),
      .OFS_W (OFS_W),
      .SHIFT (SHIFT)
   ) u_compose (
      .seg_i    (seg_value),
      .offset_i (sel_offset),
      .phys_o   (phys)
   );

   assign accept = req_valid && (req_fetch || (ea_mod != MOD_REGDIR));

   generate
      if (REG_OUT) begin : g_reg
         logic             valid_q;
         logic [PA_W-1:0]  addr_q;
         logic [OFS_W-1:0] ofs_q;
         logic [1:0]       seg_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               addr_q  <= '0;
               ofs_q   <= '0;
               seg_q   <= '0;
            end else begin
               valid_q <= accept;
               if (accept) begin
                  addr_q <= phys;
                  ofs_q  <= sel_offset;
                  seg_q  <= seg_code;
               end
            end
         end

         assign out_valid  = valid_q;
         assign out_addr   = addr_q;
         assign out_offset = ofs_q;
         assign out_seg    = seg_q;

         AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (req_fetch || ea_mod != MOD_REGDIR)) |=> out_valid); // R2
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_offset) && $stable(out_seg))); // R2
         AST_REGDIR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_fetch && ea_mod == MOD_REGDIR) |=> (!out_valid && $stable(out_addr))); // R12
         AST_FETCH_CS_IP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_fetch) |=> (out_seg == SEG_CS && out_offset == $past(reg_ip))); // R3
         AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_fetch && ovr_en && ea_mod != MOD_REGDIR) |=> (out_seg == $past(ovr_seg))); // R10
      end else begin : g_comb
         assign out_valid  = accept;
         assign out_addr   = phys;
         assign out_offset = sel_offset;
         assign out_seg    = seg_code;
      end
   endgenerate

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_fetch = 1'b0;
   logic [1:0]  ea_mod = '0;
   logic [2:0]  ea_rm = '0;
   logic [15:0] ea_disp = '0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_seg = '0;
   logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, reg_ip = '0;
   logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
   logic        out_valid;
   logic [19:0] out_addr;
   logic [15:0] out_offset;
   logic [1:0]  out_seg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [19:0] last_addr = '0;
   logic [15:0] last_ofs  = '0;
   logic [1:0]  last_seg  = '0;

   always #10 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
      .ea_mod(ea_mod), .ea_rm(ea_rm), .ea_disp(ea_disp), .ovr_en(ovr_en),
      .ovr_seg(ovr_seg), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
      .reg_di(reg_di), .reg_ip(reg_ip), .seg_es(seg_es), .seg_cs(seg_cs),
      .seg_ss(seg_ss), .seg_ds(seg_ds), .out_valid(out_valid),
      .out_addr(out_addr), .out_offset(out_offset), .out_seg(out_seg)
   );

   function automatic logic [15:0] m_offset();
      logic [15:0] d;
      logic [15:0] b;
      if (req_fetch) return reg_ip;
      case (ea_mod)
         2'd0: d = (ea_rm == 3'd6) ? ea_disp : 16'h0;
         2'd1: d = {{8{ea_disp[7]}}, ea_disp[7:0]};
         default: d = ea_disp;
      endcase
      case (ea_rm)
         3'd0: b = reg_bx + reg_si;
         3'd1: b = reg_bx + reg_di;
         3'd2: b = reg_bp + reg_si;
         3'd3: b = reg_bp + reg_di;
         3'd4: b = reg_si;
         3'd5: b = reg_di;
         3'd6: b = (ea_mod == 2'd0) ? 16'h0 : reg_bp;
         default: b = reg_bx;
      endcase
      return b + d;
   endfunction

   function automatic logic [1:0] m_seg();
      if (req_fetch) return 2'd1;
      if (ovr_en) return ovr_seg;
      if (ea_rm == 3'd2 || ea_rm == 3'd3 || (ea_rm == 3'd6 && ea_mod != 2'd0)) return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [19:0] m_addr(input logic [1:0] code, input logic [15:0] ofs);
      logic [15:0] sv;
      logic [20:0] full;
      case (code)
         2'd0: sv = seg_es;
         2'd1: sv = seg_cs;
         2'd2: sv = seg_ss;
         default: sv = seg_ds;
      endcase
      full = ({5'b0, sv} << 4) + {5'b0, ofs};
      return full[19:0];
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic rand_regs();
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      reg_ip = 16'($urandom);
      seg_es = 16'($urandom); seg_cs = 16'($urandom);
      seg_ss = 16'($urandom); seg_ds = 16'($urandom);
   endtask

   // inputs must already be set (between edges); issues one request and checks it
   task automatic run_req(input string tag);
      logic [15:0] eo;
      logic [1:0]  es;
      logic [19:0] ea;
      bit          acc;
      eo  = m_offset();
      es  = m_seg();
      ea  = m_addr(es, eo);
      acc = req_fetch || (ea_mod != 2'd3);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (acc) begin
         last_addr = ea; last_ofs = eo; last_seg = es;
      end
      chk(acc ? tag : "R12", "valid", {31'b0, out_valid}, {31'b0, acc});
      chk(tag, "offset", {16'b0, out_offset}, {16'b0, last_ofs});
      chk(tag, "seg", {30'b0, out_seg}, {30'b0, last_seg});
      chk(acc ? "R11" : "R12", "addr", {12'b0, out_addr}, {12'b0, last_addr});
   endtask

   function automatic string pick_tag();
      if (req_fetch) return "R3";
      if (ea_mod == 2'd3) return "R12";
      if (ovr_en) return "R10";
      if (ea_mod == 2'd1) return "R7";
      if (ea_mod == 2'd2) return "R8";
      if (ea_rm == 3'd6) return "R6";
      if (ea_rm < 3'd4) return "R4";
      return "R5";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid", {31'b0, out_valid}, 32'd0);
      chk("R1", "addr", {12'b0, out_addr}, 32'd0);
      chk("R1", "offset", {16'b0, out_offset}, 32'd0);
      chk("R1", "seg", {30'b0, out_seg}, 32'd0);

      // R3: fetch, top of the one-mebibyte space
      seg_cs = 16'hF000; reg_ip = 16'hFFF0; req_fetch = 1'b1;
      run_req("R3");
      chk("R3", "fetch addr", {12'b0, out_addr}, 32'hFFFF0);
      // R10: override ignored on fetch
      ovr_en = 1'b1; ovr_seg = 2'd0; seg_es = 16'h1234;
      run_req("R10");
      chk("R10", "fetch seg", {30'b0, out_seg}, 32'd1);
      ovr_en = 1'b0; req_fetch = 1'b0;

      // R4: BX+SI wrapping at 16 bits, DS default (R9)
      reg_bx = 16'hFFFF; reg_si = 16'h0002; seg_ds = 16'h2000;
      ea_mod = 2'd0; ea_rm = 3'd0;
      run_req("R4");
      chk("R4", "wrapped offset", {16'b0, out_offset}, 32'h0001);
      chk("R9", "ds default", {30'b0, out_seg}, 32'd3);
      // R9: BP+SI uses SS
      reg_bp = 16'h0100; seg_ss = 16'h3000; ea_rm = 3'd2;
      run_req("R9");
      chk("R9", "ss for bp", {30'b0, out_seg}, 32'd2);
      // R5
      reg_si = 16'h0444; reg_di = 16'h0555; reg_bx = 16'h0777;
      ea_rm = 3'd4; run_req("R5");
      ea_rm = 3'd5; run_req("R5");
      ea_rm = 3'd7; run_req("R5");
      chk("R5", "bx alone", {16'b0, out_offset}, 32'h0777);
      // R6: direct, DS even though rm 6
      ea_rm = 3'd6; ea_disp = 16'h1234;
      run_req("R6");
      chk("R6", "direct", {16'b0, out_offset}, 32'h1234);
      chk("R9", "direct uses ds", {30'b0, out_seg}, 32'd3);
      // R7: negative byte displacement, high byte ignored
      ea_mod = 2'd1; ea_disp = 16'hAB80; reg_bp = 16'h0100;
      run_req("R7");
      chk("R7", "disp8 sext", {16'b0, out_offset}, 32'h0080);
      chk("R9", "bp+disp ss", {30'b0, out_seg}, 32'd2);
      // R8
      ea_mod = 2'd2; ea_rm = 3'd7; ea_disp = 16'hF000; reg_bx = 16'h2000;
      run_req("R8");
      chk("R8", "disp16 wrap", {16'b0, out_offset}, 32'h1000);
      // R10: override ES on a BP form
      ea_mod = 2'd0; ea_rm = 3'd2; ovr_en = 1'b1; ovr_seg = 2'd0;
      run_req("R10");
      chk("R10", "es override", {30'b0, out_seg}, 32'd0);
      ovr_en = 1'b0;
      // R11: address wrap at 2^20
      seg_ds = 16'hFFFF; ea_rm = 3'd6; ea_disp = 16'hFFFF;
      run_req("R11");
      chk("R11", "phys wrap", {12'b0, out_addr}, 32'h0FFEF);
      // R2: idle hold while inputs move
      rand_regs(); ea_disp = 16'h5A5A;
      repeat (3) @(negedge clk);
      chk("R2", "idle valid", {31'b0, out_valid}, 32'd0);
      chk("R2", "idle hold", {12'b0, out_addr}, {12'b0, last_addr});
      // R12: register-direct mode dropped
      ea_mod = 2'd3; run_req("R12");

      for (int i = 0; i < 600; i++) begin
         rand_regs();
         req_fetch = ($urandom % 8) == 0;
         ea_mod    = 2'($urandom);
         ea_rm     = 3'($urandom);
         ea_disp   = 16'($urandom);
         ovr_en    = ($urandom % 4) == 0;
         ovr_seg   = 2'($urandom);
         run_req(pick_tag());
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule